// File: doc/BRIEF.md
# Dual-Path Bridge Control Register Bank

This block holds the 64-bit control and status registers of a service-processor host bridge. Two masters can reach the same storage. The configuration scan path names a register directly by its 6-bit register number. The memory-mapped path gives a byte offset, and the block turns that offset into a register number by adding a fixed bias. Every access moves one whole 64-bit word. A length other than eight bytes is refused.

Some register numbers are write aliases. They change a stored register in place rather than replace it. A fault register can be ANDed or ORed. A control register can have bits set or cleared. The window base register takes writes only from the scan path, and it keeps only its address field and its enable bit. The interrupt status register is a read-only image of an input vector, sampled on every clock. Reset clears everything, then loads the window base register from a parameter with the enable bit set.

Each path raises a request for one cycle. The block takes at most one access per cycle, and the scan path wins a collision. A taken access is acknowledged in the next cycle, on a shared response bus that carries the read data and an error flag. The arbiter is a three-state machine. The states are ST_IDLE (nothing acknowledged), ST_ACK_SCAN (a scan access is acknowledged this cycle) and ST_ACK_MAP (a mapped access is acknowledged this cycle). From every state the next state is chosen the same way: ST_ACK_SCAN if a scan request is present, else ST_ACK_MAP if a mapped request is present, else ST_IDLE.

Top module: `hbr_regbank`

## Requirements
- R1: After reset every register reads zero, except the window base (number 0x0A), which reads (BASE_DEFAULT AND BASE_MASK) OR 1.
- R2: Register numbers are decoded as follows: 0x00 fault, 0x06 and 0x07 fault actions, 0x0A window base, 0x0B second base, 0x0E control, 0x0F error mask, 0x14 DMA upper address, 0x15 interrupt status, 0x1B source compare. A plain write to any of these (except 0x15) and a read of it return the stored value.
- R3: A write to number 0x01 ANDs the data into the fault register. A write to number 0x02 ORs the data into it.
- R4: A write to number 0x12 ORs the data into control. A write to number 0x13 clears in control every bit that is set in the data.
- R5: A mapped offset selects register number (offset >> 3) + 0x0A. An offset whose low three bits are not zero, or whose register number exceeds 63, is invalid: a read returns all ones, a write changes nothing, and the error flag is raised.
- R6: A mapped write to the window base is dropped and raises the error flag. A scan write to it is accepted.
- R7: A window base write keeps only the bits in BASE_MASK (default bits 20..49) plus bit 0. A second-base write keeps only the bits in BASE2_MASK (default 0x0003FFFF00000000).
- R8: A read of any number not listed in R2 (including the aliases 0x01, 0x02, 0x12, 0x13) returns all ones and raises the error flag. A write to a number not listed in R2, R3 or R4 changes nothing and raises the error flag.
- R9: Number 0x15 reads the value istat_in had at the previous clock edge. A write to it changes nothing and raises the error flag.
- R10: An access whose length field is not 8 is refused: a read returns all ones, a write changes nothing, and the error flag is raised.
- R11: A request is acknowledged exactly one cycle after it is taken, and at most one acknowledge is high per cycle. When both paths request in the same cycle, the scan access is taken, map_stall is high, and the mapped access is not acknowledged in the next cycle.
- R12: The acknowledge of a write returns zero on rsp_data. rsp_err is high only in the acknowledge cycle of a refused or invalid access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_req | input | 1 | Scan-path request, one cycle per access |
| scan_we | input | 1 | Scan-path write when 1, read when 0 |
| scan_idx | input | 6 | Scan-path register number |
| scan_len | input | 4 | Scan-path access length in bytes |
| scan_wdata | input | 64 | Scan-path write data |
| scan_ack | output | 1 | Scan access acknowledged this cycle |
| map_req | input | 1 | Mapped-path request |
| map_we | input | 1 | Mapped-path write when 1, read when 0 |
| map_off | input | MAP_OFF_W | Mapped-path byte offset |
| map_len | input | 4 | Mapped-path access length in bytes |
| map_wdata | input | 64 | Mapped-path write data |
| map_stall | output | 1 | Mapped request lost arbitration this cycle |
| map_ack | output | 1 | Mapped access acknowledged this cycle |
| istat_in | input | 64 | Interrupt status vector sampled into register 0x15 |
| rsp_data | output | 64 | Read data of the acknowledged access |
| rsp_err | output | 1 | Acknowledged access was refused or invalid |

## Verification
The bench sets MAP_OFF_W to 9. This widens the mapped offset until the bias pushes some register numbers past 63. With that width the out-of-range rule of R5 can be reached, and so can unimplemented high numbers such as 0x3F, which the default width of 8 cannot produce. The bench also sets BASE_DEFAULT to all ones. The reset value of the window base then shows that the masking of R7 also applies to the default.

// File: rtl/hbr_regbank_pkg.sv
`timescale 1ns/1ps
package hbr_regbank_pkg;
    localparam int REG_W  = 6;
    localparam int DATA_W = 64;
    localparam int LEN_W  = 4;
    localparam logic [LEN_W-1:0] WORD_BYTES = 4'd8;

    localparam logic [REG_W-1:0] RN_FLT     = 6'h00;
    localparam logic [REG_W-1:0] RN_FLT_AND = 6'h01;
    localparam logic [REG_W-1:0] RN_FLT_OR  = 6'h02;
    localparam logic [REG_W-1:0] RN_ACT0    = 6'h06;
    localparam logic [REG_W-1:0] RN_ACT1    = 6'h07;
    localparam logic [REG_W-1:0] RN_BASE    = 6'h0A;
    localparam logic [REG_W-1:0] RN_BASE2   = 6'h0B;
    localparam logic [REG_W-1:0] RN_CTL     = 6'h0E;
    localparam logic [REG_W-1:0] RN_EMASK   = 6'h0F;
    localparam logic [REG_W-1:0] RN_CTL_SET = 6'h12;
    localparam logic [REG_W-1:0] RN_CTL_CLR = 6'h13;
    localparam logic [REG_W-1:0] RN_DMAHI   = 6'h14;
    localparam logic [REG_W-1:0] RN_ISTAT   = 6'h15;
    localparam logic [REG_W-1:0] RN_SRCCMP  = 6'h1B;

    // bias between mapped word index and register number
    localparam logic [REG_W-1:0] MAP_BIAS = RN_BASE;

    // registers with plain read/write storage
    localparam int NUM_PLAIN = 5;
    localparam logic [REG_W-1:0] PLAIN_IDX [NUM_PLAIN] =
        '{RN_ACT0, RN_ACT1, RN_EMASK, RN_DMAHI, RN_SRCCMP};

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACK_SCAN = 2'd1,
        ST_ACK_MAP  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/hbr_xlate.sv
`timescale 1ns/1ps
module hbr_xlate
    import hbr_regbank_pkg::*;
#(
    parameter bit MAPPED = 1'b0,
    parameter int ADDR_W = REG_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic [REG_W-1:0]  idx,
    output logic              bad
);
    logic len_bad;
    assign len_bad = (len != WORD_BYTES);

    generate
        if (MAPPED) begin : g_mapped
            localparam int WORD_W = ADDR_W - 3;
            localparam int SUM_W  = ((WORD_W > REG_W) ? WORD_W : REG_W) + 1;
            logic [SUM_W-1:0] sum;
            logic             misaligned;
            logic             out_of_range;
            assign sum          = SUM_W'(addr[ADDR_W-1:3]) + SUM_W'(MAP_BIAS);
            assign misaligned   = |addr[2:0];
            assign out_of_range = |sum[SUM_W-1:REG_W];
            assign idx          = sum[REG_W-1:0];
            assign bad          = len_bad | misaligned | out_of_range;
        end else begin : g_direct
            assign idx = addr[REG_W-1:0];
            assign bad = len_bad;
        end
    endgenerate
endmodule

// File: rtl/hbr_arb.sv
`timescale 1ns/1ps
module hbr_arb
    import hbr_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scan_req,
    input  logic map_req,
    output logic grant_scan,
    output logic grant_map,
    output logic map_stall,
    output logic scan_ack,
    output logic map_ack
);
    arb_state_e state_q;
    arb_state_e state_d;

    assign grant_scan = scan_req;
    assign grant_map  = map_req & ~scan_req;
    assign map_stall  = map_req & scan_req;

    always_comb begin
        if (scan_req)     state_d = ST_ACK_SCAN;
        else if (map_req) state_d = ST_ACK_MAP;
        else              state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        scan_ack = 1'b0;
        map_ack  = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_ACK_SCAN: scan_ack = 1'b1;
            ST_ACK_MAP:  map_ack  = 1'b1;
            default:     ;
        endcase
    end

    a_r11_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_ack && map_ack));
    a_r11_scan_acked: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |=> scan_ack);
    a_r11_map_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (map_req && !scan_req) |=> map_ack);
    a_r11_stall_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        map_stall |=> !map_ack);
endmodule

// File: rtl/hbr_regfile.sv
`timescale 1ns/1ps
module hbr_regfile
    import hbr_regbank_pkg::*;
#(
    parameter logic [DATA_W-1:0] BASE_DEFAULT = 64'h0000_2000_0030_0000,
    parameter logic [DATA_W-1:0] BASE_MASK    = 64'h0003_FFFF_FFF0_0000,
    parameter logic [DATA_W-1:0] BASE2_MASK   = 64'h0003_FFFF_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic              acc_from_map,
    input  logic              acc_bad,
    input  logic [REG_W-1:0]  acc_idx,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] istat_in,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err
);
    localparam logic [DATA_W-1:0] BASE_KEEP = BASE_MASK | DATA_W'(1);
    localparam logic [DATA_W-1:0] BASE_RST  = (BASE_DEFAULT & BASE_MASK) | DATA_W'(1);

    logic [DATA_W-1:0] flt_q, ctl_q, base_q, base2_q, istat_q;
    logic [DATA_W-1:0] plain_q [NUM_PLAIN];
    logic [DATA_W-1:0] rd_val;
    logic              rd_hit, wr_ok, err_now, wr_go;

    always_comb begin
        rd_val = '1;
        rd_hit = 1'b0;
        wr_ok  = 1'b0;
        case (acc_idx)
            RN_FLT:   begin rd_val = flt_q;   rd_hit = 1'b1; wr_ok = 1'b1; end
            RN_FLT_AND, RN_FLT_OR, RN_CTL_SET, RN_CTL_CLR: wr_ok = 1'b1;
            RN_CTL:   begin rd_val = ctl_q;   rd_hit = 1'b1; wr_ok = 1'b1; end
            RN_BASE:  begin rd_val = base_q;  rd_hit = 1'b1; wr_ok = ~acc_from_map; end
            RN_BASE2: begin rd_val = base2_q; rd_hit = 1'b1; wr_ok = 1'b1; end
            RN_ISTAT: begin rd_val = istat_q; rd_hit = 1'b1; end
            default: begin
                for (int k = 0; k < NUM_PLAIN; k++) begin
                    if (acc_idx == PLAIN_IDX[k]) begin
                        rd_val = plain_q[k];
                        rd_hit = 1'b1;
                        wr_ok  = 1'b1;
                    end
                end
            end
        endcase
    end

    assign err_now = acc_bad | (acc_we ? ~wr_ok : ~rd_hit);
    assign wr_go   = acc_valid & acc_we & ~acc_bad & wr_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else if (wr_go) begin
            case (acc_idx)
                RN_FLT:     flt_q <= acc_wdata;
                RN_FLT_AND: flt_q <= flt_q & acc_wdata;
                RN_FLT_OR:  flt_q <= flt_q | acc_wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_go) begin
            case (acc_idx)
                RN_CTL:     ctl_q <= acc_wdata;
                RN_CTL_SET: ctl_q <= ctl_q | acc_wdata;
                RN_CTL_CLR: ctl_q <= ctl_q & ~acc_wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= BASE_RST;
            base2_q <= '0;
            istat_q <= '0;
        end else begin
            istat_q <= istat_in;
            if (wr_go && acc_idx == RN_BASE)  base_q  <= acc_wdata & BASE_KEEP;
            if (wr_go && acc_idx == RN_BASE2) base2_q <= acc_wdata & BASE2_MASK;
        end
    end

    generate
        for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)                               plain_q[g] <= '0;
                else if (wr_go && acc_idx == PLAIN_IDX[g]) plain_q[g] <= acc_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data <= '0;
            rsp_err  <= 1'b0;
        end else begin
            rsp_err <= acc_valid & err_now;
            if (acc_valid) rsp_data <= acc_we ? '0 : (acc_bad ? '1 : rd_val);
        end
    end

    a_r6_map_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we && acc_from_map) |=> $stable(base_q));
    a_r7_base_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (base_q & ~BASE_KEEP) == '0);
    a_r10_bad_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_bad) |=> rsp_err);
    a_r9_istat_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we && acc_idx == RN_ISTAT) |=> rsp_err);
    a_r3_or_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we && !acc_bad && acc_idx == RN_FLT_OR)
        |=> ((flt_q & $past(flt_q)) == $past(flt_q)));
    a_r4_clear_drops_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we && !acc_bad && acc_idx == RN_CTL_CLR)
        |=> ((ctl_q & $past(acc_wdata)) == '0));
    a_r12_write_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we) |=> (rsp_data == '0));
endmodule

// File: rtl/hbr_regbank.sv
`timescale 1ns/1ps
module hbr_regbank
    import hbr_regbank_pkg::*;
#(
    parameter int                MAP_OFF_W    = 8,
    parameter logic [DATA_W-1:0] BASE_DEFAULT = 64'h0000_2000_0030_0000,
    parameter logic [DATA_W-1:0] BASE_MASK    = 64'h0003_FFFF_FFF0_0000,
    parameter logic [DATA_W-1:0] BASE2_MASK   = 64'h0003_FFFF_0000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_req,
    input  logic                 scan_we,
    input  logic [REG_W-1:0]     scan_idx,
    input  logic [LEN_W-1:0]     scan_len,
    input  logic [DATA_W-1:0]    scan_wdata,
    output logic                 scan_ack,
    input  logic                 map_req,
    input  logic                 map_we,
    input  logic [MAP_OFF_W-1:0] map_off,
    input  logic [LEN_W-1:0]     map_len,
    input  logic [DATA_W-1:0]    map_wdata,
    output logic                 map_stall,
    output logic                 map_ack,
    input  logic [DATA_W-1:0]    istat_in,
    output logic [DATA_W-1:0]    rsp_data,
    output logic                 rsp_err
);
    logic [REG_W-1:0] s_idx, m_idx, acc_idx;
    logic             s_bad, m_bad, acc_bad;
    logic             g_scan, g_map;

    hbr_xlate #(.MAPPED(1'b0), .ADDR_W(REG_W)) u_scan_xlate (
        .addr(scan_idx), .len(scan_len), .idx(s_idx), .bad(s_bad));

    hbr_xlate #(.MAPPED(1'b1), .ADDR_W(MAP_OFF_W)) u_map_xlate (
        .addr(map_off), .len(map_len), .idx(m_idx), .bad(m_bad));

    hbr_arb u_arb (
        .clk(clk), .rst_n(rst_n), .scan_req(scan_req), .map_req(map_req),
        .grant_scan(g_scan), .grant_map(g_map), .map_stall(map_stall),
        .scan_ack(scan_ack), .map_ack(map_ack));

    assign acc_idx = g_scan ? s_idx : m_idx;
    assign acc_bad = g_scan ? s_bad : m_bad;

    hbr_regfile #(
        .BASE_DEFAULT(BASE_DEFAULT), .BASE_MASK(BASE_MASK), .BASE2_MASK(BASE2_MASK)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(g_scan | g_map),
        .acc_we(g_scan ? scan_we : map_we),
        .acc_from_map(g_map),
        .acc_bad(acc_bad),
        .acc_idx(acc_idx),
        .acc_wdata(g_scan ? scan_wdata : map_wdata),
        .istat_in(istat_in),
        .rsp_data(rsp_data),
        .rsp_err(rsp_err));
endmodule

// File: tb/hbr_regbank_bench.sv
`timescale 1ns/1ps
module hbr_regbank_bench;
    localparam int          OFFW   = 9;
    localparam logic [63:0] BDEF   = '1;
    localparam logic [63:0] BMASK  = 64'h0003_FFFF_FFF0_0000;
    localparam logic [63:0] B2MASK = 64'h0003_FFFF_0000_0000;
    localparam logic [63:0] ONES   = '1;

    logic clk = 0, rst_n = 0;
    logic scan_req = 0, scan_we = 0, map_req = 0, map_we = 0;
    logic [5:0] scan_idx = 0;
    logic [3:0] scan_len = 8, map_len = 8;
    logic [63:0] scan_wdata = 0, map_wdata = 0, istat_in = 0;
    logic [OFFW-1:0] map_off = 0;
    logic scan_ack, map_ack, map_stall, rsp_err;
    logic [63:0] rsp_data;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [63:0] mdl [64];

    always #2.5 clk = ~clk;

    hbr_regbank #(.MAP_OFF_W(OFFW), .BASE_DEFAULT(BDEF)) u_hbr_regbank (
        .clk(clk), .rst_n(rst_n),
        .scan_req(scan_req), .scan_we(scan_we), .scan_idx(scan_idx),
        .scan_len(scan_len), .scan_wdata(scan_wdata), .scan_ack(scan_ack),
        .map_req(map_req), .map_we(map_we), .map_off(map_off),
        .map_len(map_len), .map_wdata(map_wdata), .map_stall(map_stall),
        .map_ack(map_ack), .istat_in(istat_in),
        .rsp_data(rsp_data), .rsp_err(rsp_err));

    task automatic chk(string rq, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, got, exp);
        end
    endtask

    function automatic bit readable(int unsigned r);
        return r == 'h00 || r == 'h06 || r == 'h07 || r == 'h0A || r == 'h0B ||
               r == 'h0E || r == 'h0F || r == 'h14 || r == 'h15 || r == 'h1B;
    endfunction

    // expected response from the requirements, updating the model
    task automatic predict(bit mp, bit we, int unsigned a, logic [3:0] len,
                           logic [63:0] wd, output logic [63:0] erd, output bit eer);
        int unsigned r;
        bit bad;
        r   = mp ? (a >> 3) + 10 : a;
        bad = (len != 8) || (mp && ((a % 8) != 0 || r > 63));
        erd = we ? 64'd0 : ONES;
        eer = 1'b1;
        if (bad) return;
        if (!we) begin
            if (readable(r)) begin
                erd = (r == 'h15) ? istat_in : mdl[r];
                eer = 1'b0;
            end
            return;
        end
        eer = 1'b0;
        case (r)
            'h00: mdl[0] = wd;
            'h01: mdl[0] = mdl[0] & wd;
            'h02: mdl[0] = mdl[0] | wd;
            'h06, 'h07, 'h0E, 'h0F, 'h14, 'h1B: mdl[r] = wd;
            'h0A: if (mp) eer = 1'b1; else mdl[r] = wd & (BMASK | 64'd1);
            'h0B: mdl[r] = wd & B2MASK;
            'h12: mdl['h0E] = mdl['h0E] | wd;
            'h13: mdl['h0E] = mdl['h0E] & ~wd;
            default: eer = 1'b1;
        endcase
    endtask

    task automatic run(string rq, bit mp, bit we, int unsigned a, logic [3:0] len,
                       logic [63:0] wd);
        logic [63:0] erd;
        bit eer;
        predict(mp, we, a, len, wd, erd, eer);
        @(negedge clk);
        if (mp) begin
            map_req = 1; map_we = we; map_off = OFFW'(a); map_len = len; map_wdata = wd;
        end else begin
            scan_req = 1; scan_we = we; scan_idx = 6'(a); scan_len = len; scan_wdata = wd;
        end
        @(negedge clk);
        scan_req = 0; map_req = 0;
        chk({rq, " ack (R11)"}, 64'(mp ? map_ack : scan_ack), 64'd1);
        chk({rq, " data"}, rsp_data, erd);
        chk({rq, " err (R12)"}, 64'(rsp_err), 64'(eer));
    endtask

    task automatic set_istat(logic [63:0] v);
        @(negedge clk);
        istat_in = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        mdl['h0A] = (BDEF & BMASK) | 64'd1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 idle acks", {62'd0, scan_ack, map_ack}, 64'd0);

        // R1 reset values
        foreach (mdl[i]) if (readable(i)) run("R1 reset", 0, 0, i, 8, 0);

        // R2 plain registers
        run("R2 act0 wr", 0, 1, 'h06, 8, 64'h1111_2222_3333_4444);
        run("R2 act1 wr", 0, 1, 'h07, 8, 64'hDEAD_BEEF_0000_0001);
        run("R2 emask wr", 0, 1, 'h0F, 8, 64'h8000_0000_0000_0008);
        run("R2 dmahi wr", 0, 1, 'h14, 8, 64'h0123_4567_89AB_CDEF);
        run("R2 srccmp wr", 0, 1, 'h1B, 8, 64'hFEDC_BA98_7654_3210);
        run("R2 act0 rd", 0, 0, 'h06, 8, 0);
        run("R2 act1 rd", 0, 0, 'h07, 8, 0);
        run("R2 emask rd", 0, 0, 'h0F, 8, 0);
        run("R2 dmahi rd", 0, 0, 'h14, 8, 0);
        run("R2 srccmp rd", 0, 0, 'h1B, 8, 0);

        // R3 fault aliases
        run("R3 flt wr", 0, 1, 'h00, 8, 64'hF0F0_F0F0_F0F0_F0F0);
        run("R3 flt and", 0, 1, 'h01, 8, 64'hFF00_FF00_FF00_FF00);
        run("R3 flt rd", 0, 0, 'h00, 8, 0);
        run("R3 flt or", 0, 1, 'h02, 8, 64'h000F_000F_000F_000F);
        run("R3 flt rd", 0, 0, 'h00, 8, 0);

        // R4 control set/clear
        run("R4 ctl wr", 0, 1, 'h0E, 8, 64'h0400_0000_0000_0000);
        run("R4 ctl set", 0, 1, 'h12, 8, 64'hC000_8000_0000_0000);
        run("R4 ctl rd", 0, 0, 'h0E, 8, 0);
        run("R4 ctl clr", 0, 1, 'h13, 8, 64'h4400_0000_0000_0000);
        run("R4 ctl rd", 0, 0, 'h0E, 8, 0);

        // R5 mapped translation
        run("R5 map ctl rd", 1, 0, 'h20, 8, 0);
        run("R5 map dmahi wr", 1, 1, 'h50, 8, 64'hAAAA_5555_AAAA_5555);
        run("R5 scan dmahi rd", 0, 0, 'h14, 8, 0);
        run("R5 map base rd", 1, 0, 'h00, 8, 0);
        run("R5 misaligned rd", 1, 0, 'h21, 8, 0);
        run("R5 misaligned wr", 1, 1, 'h51, 8, 64'h1);
        run("R5 scan dmahi rd", 0, 0, 'h14, 8, 0);
        run("R5 range rd", 1, 0, 'h1F8, 8, 0);
        run("R5 top number rd", 1, 0, 'h1A8, 8, 0);

        // R6 window base write protection
        run("R6 map base wr", 1, 1, 'h00, 8, 64'h0000_1000_0010_0000);
        run("R6 base rd", 0, 0, 'h0A, 8, 0);
        run("R6 scan base wr", 0, 1, 'h0A, 8, 64'h0000_1000_0010_0000);
        run("R6 base rd", 0, 0, 'h0A, 8, 0);

        // R7 masking
        run("R7 base ones", 0, 1, 'h0A, 8, ONES);
        run("R7 base rd", 0, 0, 'h0A, 8, 0);
        run("R7 base2 ones", 0, 1, 'h0B, 8, ONES);
        run("R7 base2 rd", 0, 0, 'h0B, 8, 0);

        // R8 unimplemented
        run("R8 rd 03", 0, 0, 'h03, 8, 0);
        run("R8 wr 03", 0, 1, 'h03, 8, 64'h5);
        run("R8 rd set alias", 0, 0, 'h12, 8, 0);
        run("R8 rd or alias", 0, 0, 'h02, 8, 0);

        // R9 interrupt status
        set_istat(64'h0000_0010_0000_0000);
        run("R9 istat rd", 0, 0, 'h15, 8, 0);
        run("R9 istat wr", 0, 1, 'h15, 8, 64'h0);
        run("R9 istat rd map", 1, 0, 'h58, 8, 0);

        // R10 length
        run("R10 short wr", 0, 1, 'h14, 4, 64'h7777);
        run("R10 dmahi rd", 0, 0, 'h14, 8, 0);
        run("R10 short rd", 0, 0, 'h14, 4, 0);
        run("R10 long map rd", 1, 0, 'h50, 15, 0);

        // R11 collision
        @(negedge clk);
        scan_req = 1; scan_we = 0; scan_idx = 6'h0E; scan_len = 8;
        map_req = 1; map_we = 0; map_off = 'h50; map_len = 8;
        #1 chk("R11 stall on collision", 64'(map_stall), 64'd1);
        @(negedge clk);
        scan_req = 0;
        chk("R11 scan wins", {62'd0, scan_ack, map_ack}, 64'd2);
        chk("R11 scan data", rsp_data, mdl['h0E]);
        #1 chk("R11 stall released", 64'(map_stall), 64'd0);
        @(negedge clk);
        map_req = 0;
        chk("R11 map served", {62'd0, scan_ack, map_ack}, 64'd1);
        chk("R11 map data", rsp_data, mdl['h14]);

        // random mix (R2..R12)
        for (int i = 0; i < 500; i++) begin
            int unsigned pick, a;
            bit mp, we;
            logic [3:0] len;
            logic [63:0] wd;
            logic [5:0] nums [16];
            nums = '{6'h00, 6'h01, 6'h02, 6'h06, 6'h07, 6'h0A, 6'h0B, 6'h0E,
                     6'h0F, 6'h12, 6'h13, 6'h14, 6'h15, 6'h1B, 6'h03, 6'h3F};
            if ($urandom_range(0, 19) == 0) set_istat({$urandom, $urandom});
            mp   = $urandom_range(0, 1) == 1;
            we   = $urandom_range(0, 1) == 1;
            len  = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'd8;
            wd   = {$urandom, $urandom};
            pick = nums[$urandom_range(0, 15)];
            if (mp) begin
                if (pick >= 10 && $urandom_range(0, 7) != 0) a = (pick - 10) << 3;
                else a = $urandom_range(0, (1 << OFFW) - 1);
            end else a = pick;
            run("R12 random", mp, we, a, len, wd);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule